// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a NOR-style flash controller. It observes every write cycle (strobe, address, data) and recognises the multi-cycle command protocol. Two unlock writes to fixed addresses come first. A command byte follows them, and for erase commands a second unlock pair and a final code come after that. When a sequence completes, the block emits a one-cycle request pulse for program, chip erase, sector erase, suspend, resume or reset. Any write that does not fit the expected next step drops the decoder back to idle without issuing anything.

A sector erase does not start at once. The final 30h write opens an accumulation window of `WIN_US` microseconds, measured in clock cycles from the `CLK_MHZ` parameter. Each further 30h written inside the window adds that sector to a bitmap and restarts the window. When the window runs out, the block commits the bitmap with a sector-erase request and raises the erase-timer status bit (`erase_timer_bit`). From then on the decoder ignores writes until the array side reports completion. The only exceptions are a suspend write, and a resume write while suspended.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The writes 5555h/AAh, 2AAAh/55h and 5555h/A0h, followed by any fourth write, give a `prog_req` pulse in the cycle after the fourth write. `prog_addr` and `prog_data` hold that write's address and data, even if the data is F0h.
- R2: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h and 5555h/10h give a `chip_erase_req` pulse in the cycle after the sixth write. The block then enters the busy erase state.
- R3: If the sixth write of the erase sequence carries 30h at any address, the accumulation window opens. `sect_map` sets the bit whose index is the top `SECT_BITS` address bits, and no request is issued.
- R4: Each 30h write inside the window ORs in its sector bit and restarts the count. Exactly `WIN_US*CLK_MHZ` clock edges after the last accepted 30h write with no further write, a `sect_erase_req` pulse appears while `sect_map` still holds the accumulated bits.
- R5: A 30h write that lands on the very edge where the window would expire is accepted. It restarts the window, and no request is issued on that edge.
- R6: `erase_timer_bit` is 0 when idle and while the window is open. It is 1 from the erase request (chip or sector) until erase completion.
- R7: While busy erasing, every write is ignored, with one exception: B0h gives a `suspend_req` pulse and enters the suspended state. While suspended, only 30h is accepted; it gives a `resume_req` pulse and returns to erasing. A repeated B0h and the code F0h give no pulse.
- R8: Outside the busy and suspended states, F0h at any address gives a `reset_req` pulse and returns the decoder to idle, including in the middle of a sequence.
- R9: A write whose address or data does not match the expected next step returns the decoder to idle with no pulse. The steps that follow the broken one then issue nothing.
- R10: A write other than 30h inside the window abandons the accumulation. `sect_map` clears, no sector-erase request follows, and `erase_timer_bit` stays 0.
- R11: An `erase_done` pulse while erasing returns the decoder to idle, clears `sect_map` and drops `erase_timer_bit` in the next cycle. After that, a fresh program sequence is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| erase_done | input | 1 | Pulse from array side: erase finished |
| prog_req | output | 1 | Program request pulse |
| prog_addr | output | ADDR_W | Address of the program write |
| prog_data | output | 8 | Data of the program write |
| chip_erase_req | output | 1 | Chip erase request pulse |
| sect_erase_req | output | 1 | Sector erase commit pulse |
| sect_map | output | NUM_SECT | Accumulated sectors selected for erase |
| erase_timer_bit | output | 1 | 0 while window open or idle, 1 while erase runs |
| suspend_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| reset_req | output | 1 | Reset-to-read request pulse |

## Verification
The window expiry and an incoming 30h write can fall on the same clock edge. The block must choose between committing the erase and taking one more sector. The bench provokes this by waiting exactly one cycle less than the window after the first 30h write and then placing the next 30h write on the expiry edge. It judges the result by the absence of `sect_erase_req` on that edge, by the enlarged `sect_map` with `erase_timer_bit` still 0, and by a commit exactly one full window later.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_SETUP,
    ST_SUNL1,
    ST_SUNL2,
    ST_WINDOW,
    ST_ERASE,
    ST_SUSP
  } seq_state_e;

  localparam logic [7:0] CD_KEY1   = 8'hAA;
  localparam logic [7:0] CD_KEY2   = 8'h55;
  localparam logic [7:0] CD_PROG   = 8'hA0;
  localparam logic [7:0] CD_SETUP  = 8'h80;
  localparam logic [7:0] CD_CHIP   = 8'h10;
  localparam logic [7:0] CD_SECT   = 8'h30;
  localparam logic [7:0] CD_SUSP   = 8'hB0;
  localparam logic [7:0] CD_RESUME = 8'h30;
  localparam logic [7:0] CD_RESET  = 8'hF0;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic susp;
    logic resume;
    logic reset;
  } cmd_pulse_t;

endpackage

// File: rtl/erase_window_timer.sv
module erase_window_timer #(
  parameter int WIN_CYCLES = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = restart || (run && (cnt_q != LAST + 1'b1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && !restart && (cnt_q == LAST);

  // R4: while the window runs the count never passes its last value
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= LAST));

endmodule

// File: rtl/sector_bitmap.sv
module sector_bitmap #(
  parameter int NUM_SECT = 8,
  localparam int SB = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add,
  input  logic [SB-1:0]       idx,
  input  logic                clr,
  output logic [NUM_SECT-1:0] map
);
  logic [NUM_SECT-1:0] map_d;
  logic                map_en;

  assign map_en = add || clr;

  always_comb begin
    map_d = map;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (clr)                       map_d[i] = 1'b0;
      else if (add && (idx == SB'(i))) map_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map <= '0;
    else if (map_en) map <= map_d;
  end

  // R3: adding a sector never removes one already selected
  a_r3_add_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr) |=> ((map & $past(map)) == $past(map)));

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_BITS = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR1 = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR2 = 16'h2AAA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 win_expired,
  input  logic                 erase_done,
  output cmd_pulse_t           pulse,
  output logic [ADDR_W-1:0]    prog_addr,
  output logic [7:0]           prog_data,
  output logic                 win_run,
  output logic                 win_restart,
  output logic                 map_add,
  output logic [SECT_BITS-1:0] map_idx,
  output logic                 map_clr,
  output logic                 busy
);
  seq_state_e st_q, st_d;
  cmd_pulse_t pulse_d;
  logic       cap_en;
  logic       at_a1, at_a2, is_rst;

  assign at_a1  = (wr_addr == KEY_ADDR1);
  assign at_a2  = (wr_addr == KEY_ADDR2);
  assign is_rst = (wr_data == CD_RESET);
  assign map_idx = wr_addr[ADDR_W-1 -: SECT_BITS];

  always_comb begin
    st_d        = st_q;
    pulse_d     = '0;
    win_restart = 1'b0;
    map_add     = 1'b0;
    map_clr     = 1'b0;
    cap_en      = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_SETUP: if (wr_stb) begin
        st_d = ST_IDLE;
        if (is_rst) pulse_d.reset = 1'b1;
        else if (at_a1 && wr_data == CD_KEY1)
          st_d = (st_q == ST_IDLE) ? ST_UNL1 : ST_SUNL1;
      end
      ST_UNL1, ST_SUNL1: if (wr_stb) begin
        st_d = ST_IDLE;
        if (is_rst) pulse_d.reset = 1'b1;
        else if (at_a2 && wr_data == CD_KEY2)
          st_d = (st_q == ST_UNL1) ? ST_UNL2 : ST_SUNL2;
      end
      ST_UNL2: if (wr_stb) begin
        st_d = ST_IDLE;
        if (is_rst) pulse_d.reset = 1'b1;
        else if (at_a1 && wr_data == CD_PROG)  st_d = ST_PROG;
        else if (at_a1 && wr_data == CD_SETUP) st_d = ST_SETUP;
      end
      ST_PROG: if (wr_stb) begin
        st_d         = ST_IDLE;
        pulse_d.prog = 1'b1;
        cap_en       = 1'b1;
      end
      ST_SUNL2: if (wr_stb) begin
        st_d = ST_IDLE;
        if (is_rst) pulse_d.reset = 1'b1;
        else if (at_a1 && wr_data == CD_CHIP) begin
          st_d         = ST_ERASE;
          pulse_d.chip = 1'b1;
        end else if (wr_data == CD_SECT) begin
          st_d        = ST_WINDOW;
          win_restart = 1'b1;
          map_add     = 1'b1;
        end
      end
      ST_WINDOW: begin
        if (wr_stb) begin
          if (wr_data == CD_SECT) begin
            win_restart = 1'b1;
            map_add     = 1'b1;
          end else begin
            st_d          = ST_IDLE;
            map_clr       = 1'b1;
            pulse_d.reset = is_rst;
          end
        end else if (win_expired) begin
          st_d         = ST_ERASE;
          pulse_d.sect = 1'b1;
        end
      end
      ST_ERASE: begin
        if (erase_done) begin
          st_d    = ST_IDLE;
          map_clr = 1'b1;
        end else if (wr_stb && wr_data == CD_SUSP) begin
          st_d         = ST_SUSP;
          pulse_d.susp = 1'b1;
        end
      end
      ST_SUSP: if (wr_stb && wr_data == CD_RESUME) begin
        st_d           = ST_ERASE;
        pulse_d.resume = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pulse <= '0;
    end else begin
      st_q  <= st_d;
      pulse <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (cap_en) begin
      prog_addr <= wr_addr;
      prog_data <= wr_data;
    end
  end

  assign win_run = (st_q == ST_WINDOW);
  assign busy    = (st_q == ST_ERASE) || (st_q == ST_SUSP);

  // R7: a suspend pulse is only ever produced from the erasing state
  a_r7_susp_src: assert property (@(posedge clk) disable iff (!rst_n)
    pulse.susp |-> ($past(st_q) == ST_ERASE) && (st_q == ST_SUSP));

  // R5: a 30h write in the window keeps the window open on that edge
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (win_run && wr_stb && wr_data == CD_SECT) |=> (st_q == ST_WINDOW) && !pulse.sect);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_SECT = 8,
  parameter int CLK_MHZ  = 125,
  parameter int WIN_US   = 50,
  parameter logic [ADDR_W-1:0] KEY_ADDR1 = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR2 = 16'h2AAA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                erase_done,
  output logic                prog_req,
  output logic [ADDR_W-1:0]   prog_addr,
  output logic [7:0]          prog_data,
  output logic                chip_erase_req,
  output logic                sect_erase_req,
  output logic [NUM_SECT-1:0] sect_map,
  output logic                erase_timer_bit,
  output logic                suspend_req,
  output logic                resume_req,
  output logic                reset_req
);
  localparam int SECT_BITS  = $clog2(NUM_SECT);
  localparam int WIN_CYCLES = WIN_US * CLK_MHZ;

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  cmd_pulse_t           pulse;
  logic                 win_run, win_restart, win_expired;
  logic                 map_add, map_clr;
  logic [SECT_BITS-1:0] map_idx;

  cmd_seq_fsm #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS),
    .KEY_ADDR1(KEY_ADDR1), .KEY_ADDR2(KEY_ADDR2)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_expired(win_expired), .erase_done(erase_done),
    .pulse(pulse), .prog_addr(prog_addr), .prog_data(prog_data),
    .win_run(win_run), .win_restart(win_restart),
    .map_add(map_add), .map_idx(map_idx), .map_clr(map_clr),
    .busy(erase_timer_bit)
  );

  erase_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_s_n),
    .run(win_run), .restart(win_restart), .expired(win_expired)
  );

  sector_bitmap #(.NUM_SECT(NUM_SECT)) u_map (
    .clk(clk), .rst_n(rst_s_n),
    .add(map_add), .idx(map_idx), .clr(map_clr), .map(sect_map)
  );

  assign prog_req       = pulse.prog;
  assign chip_erase_req = pulse.chip;
  assign sect_erase_req = pulse.sect;
  assign suspend_req    = pulse.susp;
  assign resume_req     = pulse.resume;
  assign reset_req      = pulse.reset;

  // R1: request pulses are mutually exclusive
  a_r1_one_req: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({prog_req, chip_erase_req, sect_erase_req, suspend_req, resume_req, reset_req}));

  // R4: a sector erase commit always carries at least one sector
  a_r4_map_nonzero: assert property (@(posedge clk) disable iff (!rst_s_n)
    sect_erase_req |-> (sect_map != '0));

  // R6: the timer bit rises only together with an erase request
  a_r6_rise_commit: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(erase_timer_bit) |-> (sect_erase_req || chip_erase_req));

  // R7: while busy, neither program nor reset requests appear
  a_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (erase_timer_bit && $past(erase_timer_bit)) |-> (!prog_req && !reset_req));

  // R11: leaving the busy state leaves the sector map empty
  a_r11_map_cleared: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(erase_timer_bit) |-> (sect_map == '0));

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int WIN = 50 * 125;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        erase_done;
  logic        prog_req, chip_erase_req, sect_erase_req;
  logic        suspend_req, resume_req, reset_req, erase_timer_bit;
  logic [15:0] prog_addr;
  logic [7:0]  prog_data;
  logic [7:0]  sect_map;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .erase_done(erase_done),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_req(chip_erase_req), .sect_erase_req(sect_erase_req),
    .sect_map(sect_map), .erase_timer_bit(erase_timer_bit),
    .suspend_req(suspend_req), .resume_req(resume_req), .reset_req(reset_req)
  );

  // vector: {req id, addr, data, expected pulses {prog,chip,sect,susp,resume,reset}}
  localparam int NV = 29;
  localparam logic [33:0] VEC [NV] = '{
    {4'd1, 16'h5555, 8'hAA, 6'b000000},  // R1 program
    {4'd1, 16'h2AAA, 8'h55, 6'b000000},
    {4'd1, 16'h5555, 8'hA0, 6'b000000},
    {4'd1, 16'h1234, 8'h5A, 6'b100000},
    {4'd9, 16'h5555, 8'hAA, 6'b000000},  // R9 broken address
    {4'd9, 16'h1111, 8'h55, 6'b000000},
    {4'd9, 16'h2AAA, 8'h55, 6'b000000},
    {4'd9, 16'h5555, 8'hA0, 6'b000000},
    {4'd9, 16'h4321, 8'h77, 6'b000000},
    {4'd8, 16'h7777, 8'hF0, 6'b000001},  // R8 reset from idle
    {4'd8, 16'h5555, 8'hAA, 6'b000000},  // R8 reset mid-sequence
    {4'd8, 16'h2AAA, 8'h55, 6'b000000},
    {4'd8, 16'h0001, 8'hF0, 6'b000001},
    {4'd8, 16'h1234, 8'h11, 6'b000000},
    {4'd1, 16'h5555, 8'hAA, 6'b000000},  // R1 program data F0h
    {4'd1, 16'h2AAA, 8'h55, 6'b000000},
    {4'd1, 16'h5555, 8'hA0, 6'b000000},
    {4'd1, 16'h0ABC, 8'hF0, 6'b100000},
    {4'd2, 16'h5555, 8'hAA, 6'b000000},  // R2 chip erase
    {4'd2, 16'h2AAA, 8'h55, 6'b000000},
    {4'd2, 16'h5555, 8'h80, 6'b000000},
    {4'd2, 16'h5555, 8'hAA, 6'b000000},
    {4'd2, 16'h2AAA, 8'h55, 6'b000000},
    {4'd2, 16'h5555, 8'h10, 6'b010000},
    {4'd7, 16'h5555, 8'hAA, 6'b000000},  // R7 busy: ignored
    {4'd7, 16'h7777, 8'hF0, 6'b000000},
    {4'd7, 16'h0000, 8'hB0, 6'b000100},
    {4'd7, 16'h0000, 8'hB0, 6'b000000},
    {4'd7, 16'h0000, 8'h30, 6'b000010}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] pulses();
    return {prog_req, chip_erase_req, sect_erase_req, suspend_req, resume_req, reset_req};
  endfunction

  // called at a negedge; the write lands on the next posedge; returns at the negedge after
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic erase_setup();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
  endtask

  task automatic finish_erase(input string req);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    chk(erase_timer_bit == 1'b0 && sect_map == 8'h00, req, {erase_timer_bit, sect_map}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0; erase_done = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    // reset state (R6)
    chk({pulses(), erase_timer_bit, sect_map} == 15'h0, "R6 reset", {pulses(), erase_timer_bit, sect_map}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [15:0] a;
      logic [7:0]  d;
      logic [5:0]  e;
      {rq, a, d, e} = VEC[i];
      wr(a, d);
      chk(pulses() == e, $sformatf("R%0d vec%0d", rq, i), {26'h0, pulses()}, {26'h0, e});
    end

    // R6/R7: still busy after the table, suspend/resume did not finish the erase
    chk(erase_timer_bit == 1'b1, "R6 busy", erase_timer_bit, 1);
    finish_erase("R11 chip done");

    // R11 then R1: new program with captured address and data
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(16'hBEEF, 8'h3C);
    chk(prog_req && prog_addr == 16'hBEEF && prog_data == 8'h3C, "R1 capture",
        {prog_req, prog_addr, prog_data}, {1'b1, 16'hBEEF, 8'h3C});

    // R3/R4: sector 2 then sector 5 with restart
    erase_setup();
    wr(16'h4000, 8'h30);
    chk(sect_map == 8'h04 && !erase_timer_bit && pulses() == 6'h0, "R3 open", {sect_map, erase_timer_bit}, {8'h04, 1'b0});
    wait_cyc(WIN - 10);
    chk(pulses() == 6'h0 && !erase_timer_bit, "R4 still open", {pulses(), erase_timer_bit}, 0);
    wr(16'hA000, 8'h30);
    chk(sect_map == 8'h24, "R4 add", sect_map, 8'h24);
    wait_cyc(WIN - 1);
    chk(!sect_erase_req && !erase_timer_bit, "R4 restart", {sect_erase_req, erase_timer_bit}, 0);
    wait_cyc(1);
    chk(sect_erase_req && erase_timer_bit && sect_map == 8'h24, "R4 commit",
        {sect_erase_req, erase_timer_bit, sect_map}, {1'b1, 1'b1, 8'h24});
    wr(16'h0000, 8'hF0);
    chk(pulses() == 6'h0 && erase_timer_bit, "R7 reset ignored", {pulses(), erase_timer_bit}, 1);
    wr(16'h0000, 8'hB0);
    chk(suspend_req && erase_timer_bit, "R7 suspend", {suspend_req, erase_timer_bit}, 3);
    wr(16'h0000, 8'hF0);
    chk(pulses() == 6'h0, "R7 suspended F0 ignored", pulses(), 0);
    wr(16'h0000, 8'h30);
    chk(resume_req, "R7 resume", resume_req, 1);
    finish_erase("R11 sector done");

    // R5: second 30h on the expiry edge
    erase_setup();
    wr(16'h2000, 8'h30);
    wait_cyc(WIN - 1);
    wr(16'hE000, 8'h30);
    chk(!sect_erase_req && !erase_timer_bit && sect_map == 8'h82, "R5 coincide",
        {sect_erase_req, erase_timer_bit, sect_map}, {1'b0, 1'b0, 8'h82});
    wait_cyc(WIN - 1);
    chk(!sect_erase_req, "R5 restarted", sect_erase_req, 0);
    wait_cyc(1);
    chk(sect_erase_req && sect_map == 8'h82, "R5 commit", {sect_erase_req, sect_map}, {1'b1, 8'h82});
    finish_erase("R11 done again");

    // R10: foreign write abandons the window
    erase_setup();
    wr(16'h6000, 8'h30);
    chk(sect_map == 8'h08, "R10 open", sect_map, 8'h08);
    wr(16'h5555, 8'hAA);
    chk(sect_map == 8'h00 && pulses() == 6'h0, "R10 abandon", {pulses(), sect_map}, 0);
    wait_cyc(WIN + 5);
    chk(!erase_timer_bit && sect_map == 8'h00, "R10 no commit", {erase_timer_bit, sect_map}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule